// File: doc/BRIEF.md
# One-Time-Programmable Word Memory with Mode Decode

This block is a clocked model of a one-time-programmable memory organised as 16-bit words behind an 18-bit word address. The pins of the memory are modelled as plain signals. Chip enable and output enable are both active low. Two flags replace analog conditions: `prog_supply_hi` says the programming supply is raised, and `id_volts_a9` says address bit 9 carries the high identification voltage. The data path is split into `wr_data` in, `rd_data` out and `rd_drive`. When `rd_drive` is low, the pin would be high impedance and `rd_data` reads zero.

Each cycle, the pin state is decoded into one operating mode: read, output off, standby, program, verify, program inhibit or identification. The output register is loaded from that mode. A program operation is armed while the program combination is held. It is committed when chip enable rises, as seen in the clock domain. The commit can only clear bits of the stored word. The number of words actually stored is set by the parameter `WORDS`, and the low address bits select among them. This keeps simulation small while the full address width stays at the pins.

Top module: `otp_word_mem`

## Requirements
- R1: After reset, `rd_drive` is 0 and every location holds 0xFFFF.
- R2: With the supply flag low, chip enable low and output enable low, the cycle after the inputs are sampled shows `rd_drive`=1 and `rd_data` equal to the word at index `addr mod WORDS`.
- R3: Whenever output enable is high at a sampling edge, the next cycle shows `rd_drive`=0 and `rd_data`=0, whatever the address and the other inputs.
- R4: With the supply flag low and chip enable high (standby), the next cycle shows `rd_drive`=0 and `rd_data`=0, even when output enable is low.
- R5: Holding the supply flag high, chip enable low and output enable high arms a program operation for the presented address and data. The first edge that then samples chip enable high stores old AND data into that location, once per enable pulse.
- R6: A program operation never sets a bit: writing 0xFFFF over a programmed word leaves it unchanged.
- R7: With the supply flag high, chip enable high and output enable low (verify), the next cycle drives the stored word at the address.
- R8: With the supply flag high and both enables high (inhibit), the outputs are off and no location changes, whatever the data input holds.
- R9: Identification applies when chip enable is low, output enable is low, `id_volts_a9` is set, and every address bit other than bits 0 and 9 is low. It then returns 0x001E for bit 0 low and 0x00F4 for bit 0 high, instead of any array data.
- R10: If any address bit from 1 to 17 other than bit 9 is high, or if `id_volts_a9` is clear, a read returns array data instead of an identification word.
- R11: If output enable falls while a program operation is armed, and only then chip enable rises, nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; erases the array |
| addr | input | 18 | Word address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| prog_supply_hi | input | 1 | Programming supply raised |
| id_volts_a9 | input | 1 | High identification voltage present on address bit 9 |
| wr_data | input | 16 | Data to program |
| rd_data | output | 16 | Output word, zero while not driven |
| rd_drive | output | 1 | Output driver enable |

## Verification
The hardest state to reach is an armed program operation that is abandoned. Output enable must fall while chip enable is still low, and chip enable must rise only afterwards. A correct design then leaves the word untouched. A design that commits on any chip-enable rise would clear bits. The bench builds this exact sequence with all-zero data over a known word, then reads the word back. The identification guard is swept with one extra address bit raised at a time, across every position except bit 9, and each case must return array data.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        MODE_STANDBY = 3'd0,
        MODE_READ    = 3'd1,
        MODE_OUT_OFF = 3'd2,
        MODE_PROGRAM = 3'd3,
        MODE_VERIFY  = 3'd4,
        MODE_INHIBIT = 3'd5,
        MODE_IDENT   = 3'd6
    } otp_mode_e;

    localparam logic [15:0] ID_MAKER_WORD  = 16'h001E;
    localparam logic [15:0] ID_DEVICE_WORD = 16'h00F4;

    function automatic logic mode_drives(input otp_mode_e m);
        return (m == MODE_READ) || (m == MODE_VERIFY) || (m == MODE_IDENT);
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int HV_BIT = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              supply_hi,
    input  logic              hv_flag,
    output otp_mode_e         mode
);

    localparam logic [ADDR_W-1:0] ONE     = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] ID_MASK = ~((ONE << HV_BIT) | ONE);

    logic id_hit;

    always_comb begin
        id_hit = !ce_n && !oe_n && hv_flag && ((addr & ID_MASK) == '0);
        if (id_hit) begin
            mode = MODE_IDENT;
        end else if (!supply_hi) begin
            if (ce_n)      mode = MODE_STANDBY;
            else if (oe_n) mode = MODE_OUT_OFF;
            else           mode = MODE_READ;
        end else begin
            unique case ({ce_n, oe_n})
                2'b00:   mode = MODE_READ;
                2'b01:   mode = MODE_PROGRAM;
                2'b10:   mode = MODE_VERIFY;
                default: mode = MODE_INHIBIT;
            endcase
        end
    end

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
    import otp_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  otp_mode_e         mode,
    input  logic              ce_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] din,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        logic              armed;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } prog_state_t;

    prog_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.armed = (mode == MODE_PROGRAM);
        if (mode == MODE_PROGRAM) begin
            s_d.idx  = idx;
            s_d.data = din;
        end
        wr_en   = s_q.armed && ce_n;
        wr_idx  = s_q.idx;
        wr_data = s_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/otp_array.sv
module otp_array #(
    parameter int WORDS  = 64,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] cell_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [DATA_W-1:0] cell_d;

        always_comb begin
            cell_d = cell_q[w];
            if (wr_en && (wr_idx == IDX_W'(w))) begin
                cell_d = cell_q[w] & wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q[w] <= '1;
            end else begin
                cell_q[w] <= cell_d;
            end
        end
    end

    always_comb begin
        rd_word = cell_q[rd_idx];
    end

endmodule

// File: rtl/otp_word_mem.sv
module otp_word_mem
    import otp_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int WORDS  = 64,
    parameter int HV_BIT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              prog_supply_hi,
    input  logic              id_volts_a9,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);

    localparam int IDX_W = $clog2(WORDS);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              drive;
    } out_state_t;

    otp_mode_e         mode;
    logic [IDX_W-1:0]  idx;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_word;
    logic [DATA_W-1:0] array_word;
    out_state_t        o_d, o_q;

    assign idx = addr[IDX_W-1:0];

    otp_mode_decode #(
        .ADDR_W (ADDR_W),
        .HV_BIT (HV_BIT)
    ) u_decode (
        .addr      (addr),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .supply_hi (prog_supply_hi),
        .hv_flag   (id_volts_a9),
        .mode      (mode)
    );

    otp_prog_ctrl #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_prog (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .ce_n    (ce_n),
        .idx     (idx),
        .din     (wr_data),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_word)
    );

    otp_array #(
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_word),
        .rd_idx  (idx),
        .rd_word (array_word)
    );

    always_comb begin
        o_d.drive = mode_drives(mode);
        o_d.data  = '0;
        if (mode == MODE_IDENT) begin
            o_d.data = addr[0] ? DATA_W'(ID_DEVICE_WORD) : DATA_W'(ID_MAKER_WORD);
        end else if (o_d.drive) begin
            o_d.data = array_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign rd_data  = o_q.data;
    assign rd_drive = o_q.drive;

endmodule

module otp_word_mem_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ce_n,
    input logic              oe_n,
    input logic              prog_supply_hi,
    input logic              id_volts_a9,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_drive,
    input logic              wr_en
);

    logic live_q;
    logic id_pins;

    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    assign id_pins = !ce_n && !oe_n && id_volts_a9
                     && ({addr[ADDR_W-1:10], addr[8:1]} == '0);

    p_off_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> (rd_data == '0));

    p_oe_high_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(oe_n) |-> !rd_drive);

    p_standby_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(ce_n && !prog_supply_hi) |-> !rd_drive);

    p_verify_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(prog_supply_hi && ce_n && !oe_n) |-> rd_drive);

    p_ident_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(id_pins) |->
            rd_drive && (rd_data == ($past(addr[0]) ? DATA_W'(16'h00F4) : DATA_W'(16'h001E))));

    p_write_on_ce_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && wr_en |-> ce_n && $past(!ce_n && oe_n && prog_supply_hi));

endmodule

bind otp_word_mem otp_word_mem_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .addr           (addr),
    .ce_n           (ce_n),
    .oe_n           (oe_n),
    .prog_supply_hi (prog_supply_hi),
    .id_volts_a9    (id_volts_a9),
    .rd_data        (rd_data),
    .rd_drive       (rd_drive),
    .wr_en          (wr_en)
);

// File: tb/test_otp_word_mem.sv
`timescale 1ns/1ps
module test_otp_word_mem;

    localparam int WORDS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] addr = '0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        prog_supply_hi = 1'b0;
    logic        id_volts_a9 = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        rd_drive;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [15:0] model [WORDS];

    always #2.5 clk = ~clk;

    otp_word_mem #(.WORDS(WORDS)) i_otp_word_mem (
        .clk (clk), .rst_n (rst_n), .addr (addr), .ce_n (ce_n), .oe_n (oe_n),
        .prog_supply_hi (prog_supply_hi), .id_volts_a9 (id_volts_a9),
        .wr_data (wr_data), .rd_data (rd_data), .rd_drive (rd_drive)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, cycles=%0d expected below 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic apply(input logic [17:0] a, input logic ce, input logic oe,
                         input logic vpp, input logic hv, input logic [15:0] d);
        @(negedge clk);
        addr = a; ce_n = ce; oe_n = oe; prog_supply_hi = vpp; id_volts_a9 = hv; wr_data = d;
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic en, input logic [15:0] val);
        checks++;
        if (rd_drive !== en || rd_data !== val) begin
            errors++;
            $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h", tag, rd_drive, rd_data, en, val);
        end
    endtask

    task automatic do_read(input string tag, input logic [17:0] a);
        apply(a, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
        tick;
        expect_out(tag, 1'b1, model[a[3:0]]);
    endtask

    task automatic do_verify(input string tag, input logic [17:0] a);
        apply(a, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0);
        tick;
        expect_out(tag, 1'b1, model[a[3:0]]);
    endtask

    task automatic do_program(input logic [17:0] a, input logic [15:0] d, input int hold);
        apply(a, 1'b0, 1'b1, 1'b1, 1'b0, d);
        for (int h = 0; h < hold; h++) tick;
        apply(a, 1'b1, 1'b1, 1'b1, 1'b0, d);
        tick;
        model[a[3:0]] = model[a[3:0]] & d;
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'hFFFF ^ (16'h0001 << i) ^ (16'(i) << 8) ^ 16'h0420;
    endfunction

    initial begin
        for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
        repeat (4) tick;
        @(negedge clk); rst_n = 1'b1;
        tick;
        expect_out("R1 reset outputs off", 1'b0, 16'h0);
        for (int i = 0; i < WORDS; i++) do_read("R1 erased word", 18'(i));

        // R3: output enable high turns outputs off (non-program combinations)
        for (int v = 0; v < 8; v++) begin
            apply(18'(v * 1111), 1'b1, 1'b1, v[0], v[1], 16'h0);
            tick;
            expect_out("R3 oe high off", 1'b0, 16'h0);
        end
        apply(18'h00005, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
        tick;
        expect_out("R3 oe high ce low off", 1'b0, 16'h0);

        // R4: standby with output enable low
        for (int v = 0; v < 4; v++) begin
            apply(18'(v * 37), 1'b1, 1'b0, 1'b0, v[0], 16'h0);
            tick;
            expect_out("R4 standby off", 1'b0, 16'h0);
        end

        // R5: program every location, through aliased addresses
        for (int i = 0; i < WORDS; i++) do_program(18'(i + (i << 5)), pat(i), 1 + (i % 3));
        for (int i = 0; i < WORDS; i++) do_read("R2 read after program", 18'(i + (WORDS * 3)));
        for (int i = 0; i < WORDS; i++) do_verify("R7 verify word", 18'(i));

        // R6: writing ones changes nothing
        for (int i = 0; i < WORDS; i++) do_program(18'(i), 16'hFFFF, 1);
        for (int i = 0; i < WORDS; i++) do_read("R6 ones keep word", 18'(i));

        // R5: second pass is ANDed in
        for (int i = 0; i < WORDS; i++) do_program(18'(i), ~(16'(i) * 16'h0101), 1);
        for (int i = 0; i < WORDS; i++) do_read("R5 and merge", 18'(i));

        // R8: inhibit with zero data leaves array
        for (int i = 0; i < WORDS; i++) begin
            apply(18'(i), 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000);
            tick;
            expect_out("R8 inhibit off", 1'b0, 16'h0);
        end
        for (int i = 0; i < WORDS; i++) do_read("R8 inhibit kept word", 18'(i));

        // R11: abandoned program operation
        apply(18'd3, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000);
        tick;
        apply(18'd3, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000);
        tick;
        apply(18'd3, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000);
        tick;
        do_read("R11 abandoned program", 18'd3);

        // R9: identification words
        apply(18'h00000, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
        tick;
        expect_out("R9 maker word", 1'b1, 16'h001E);
        apply(18'h00001, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
        tick;
        expect_out("R9 device word", 1'b1, 16'h00F4);
        apply(18'h00200, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
        tick;
        expect_out("R9 bit9 allowed maker", 1'b1, 16'h001E);
        apply(18'h00201, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
        tick;
        expect_out("R9 bit9 allowed device", 1'b1, 16'h00F4);

        // R10: identification blocked
        for (int b = 1; b < 18; b++) begin
            if (b != 9) begin
                apply(18'(1) | (18'(1) << b), 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
                tick;
                expect_out("R10 extra bit gives array", 1'b1, model[(18'(1) | (18'(1) << b)) & 18'hF]);
            end
        end
        do_read("R10 flag clear gives array", 18'd0);
        do_read("R10 flag clear gives array", 18'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule